// File: doc/BRIEF.md
# Divider Configuration Latch

This block keeps the configuration word of a frequency synthesizer: a 7-bit feedback divider value and a 2-bit post-divider code. The word can come from either of two places. One is a set of parallel input pins, guarded by an active-low lock strobe. The other is a 9-bit serial shift chain, fed one bit at a time from a data pin on each rising edge of a serial clock pin and copied into the configuration under a transfer strobe.

All logic runs on one system clock. The strobes and the serial clock are sampled on that clock. The "transparent" behaviour of each path becomes a register that reloads on every cycle the path is open. Each path "captures" by leaving the register at the last value it loaded when the path closes. The outputs drive the divider logic directly.

Top module: `div_cfg_latch`

## Requirements
- R1: While reset is asserted, and immediately after it is released, the outputs read feedback divider 127 (all ones) and post-divider code 3 (all ones).
- R2: While `par_lock` is low, on each clock edge the outputs take the values on `fb_div_in` and `post_code_in`. They are visible one clock later.
- R3: After `par_lock` rises, the outputs keep the last parallel values loaded, and later changes on the parallel inputs have no effect.
- R4: Each rising edge of `ser_clk` shifts the sampled `ser_din` into the shift chain. After nine edges, the first bit shifted in is post-code bit 1, then post-code bit 0, then feedback bits 6 down to 0.
- R5: While `ser_xfer` is high and `par_lock` is high, on each clock edge the outputs take the shift chain contents. After `ser_xfer` falls they hold the last word copied.
- R6: Shifting while `ser_xfer` is low leaves the outputs unchanged.
- R7: When `par_lock` is low and `ser_xfer` is high together, the parallel inputs win.
- R8: `ser_clk` held high for several system clocks causes exactly one shift.
- R9: With `par_lock` high and `ser_xfer` low, the outputs hold for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_lock | input | 1 | Low opens the parallel path; high holds |
| fb_div_in | input | 7 | Parallel feedback divider value |
| post_code_in | input | 2 | Parallel post-divider code |
| ser_clk | input | 1 | Serial shift clock, sampled on clk |
| ser_din | input | 1 | Serial data bit |
| ser_xfer | input | 1 | High opens the serial transfer path |
| fb_div | output | 7 | Configured feedback divider value |
| post_code | output | 2 | Configured post-divider code |

## Verification
The assertions assume that every strobe, serial clock and data input is synchronous to the system clock, so each rising edge of `ser_clk` is seen exactly once. They also assume that `ser_din` is steady on the cycle the edge is detected. The bench changes every input only on the falling edge of the system clock. It keeps `ser_clk` low for at least one full system cycle between shifts, so no edge is missed or seen twice.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_PAR  = 2'd1,
    SRC_SER  = 2'd2
  } load_src_e;

  localparam int FB_W_DEF   = 7;
  localparam int POST_W_DEF = 2;
endpackage

// File: rtl/dcl_shift_chain.sv
module dcl_shift_chain #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_clk,
  input  logic         ser_din,
  output logic         shift_evt,
  output logic [W-1:0] shift_word
);
  logic         clk_prev_q;
  logic [W-1:0] sr_q;

  function automatic logic [W-1:0] shift_in(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  assign shift_evt  = ser_clk & ~clk_prev_q;
  assign shift_word = sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b0;
      sr_q       <= '1;
    end else begin
      clk_prev_q <= ser_clk;
      if (shift_evt) sr_q <= shift_in(sr_q, ser_din);
    end
  end
endmodule

// File: rtl/dcl_load_arb.sv
module dcl_load_arb (
  input  logic              par_lock,
  input  logic              ser_xfer,
  output dcl_pkg::load_src_e src
);
  always_comb begin
    if (!par_lock)     src = dcl_pkg::SRC_PAR;
    else if (ser_xfer) src = dcl_pkg::SRC_SER;
    else               src = dcl_pkg::SRC_HOLD;
  end
endmodule

// File: rtl/dcl_cfg_reg.sv
module dcl_cfg_reg #(
  parameter int W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dcl_pkg::load_src_e src,
  input  logic [W-1:0]       par_word,
  input  logic [W-1:0]       ser_word,
  output logic [W-1:0]       word_q
);
  logic [W-1:0] next_word;

  always_comb begin
    unique case (src)
      dcl_pkg::SRC_PAR: next_word = par_word;
      dcl_pkg::SRC_SER: next_word = ser_word;
      default:          next_word = word_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '1;
    else        word_q <= next_word;
  end
endmodule

// File: rtl/div_cfg_latch.sv
module div_cfg_latch #(
  parameter int FB_W   = dcl_pkg::FB_W_DEF,
  parameter int POST_W = dcl_pkg::POST_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_lock,
  input  logic [FB_W-1:0]   fb_div_in,
  input  logic [POST_W-1:0] post_code_in,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ser_xfer,
  output logic [FB_W-1:0]   fb_div,
  output logic [POST_W-1:0] post_code
);
  localparam int W = FB_W + POST_W;

  logic               shift_evt;
  logic [W-1:0]       shift_word;
  logic [W-1:0]       par_word;
  logic [W-1:0]       cfg_word;
  dcl_pkg::load_src_e src;

  assign par_word = {post_code_in, fb_div_in};

  dcl_shift_chain #(.W(W)) u_chain (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .shift_evt(shift_evt), .shift_word(shift_word)
  );

  dcl_load_arb u_arb (.par_lock(par_lock), .ser_xfer(ser_xfer), .src(src));

  dcl_cfg_reg #(.W(W)) u_reg (
    .clk(clk), .rst_n(rst_n), .src(src), .par_word(par_word),
    .ser_word(shift_word), .word_q(cfg_word)
  );

  assign fb_div    = cfg_word[FB_W-1:0];
  assign post_code = cfg_word[W-1:FB_W];
endmodule

// File: rtl/div_cfg_latch_chk.sv
module div_cfg_latch_chk #(
  parameter int FB_W   = 7,
  parameter int POST_W = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     par_lock,
  input logic                     ser_xfer,
  input logic                     ser_din,
  input logic                     shift_evt,
  input logic [FB_W+POST_W-1:0]   shift_word,
  input logic [FB_W-1:0]          fb_div_in,
  input logic [POST_W-1:0]        post_code_in,
  input logic [FB_W-1:0]          fb_div,
  input logic [POST_W-1:0]        post_code
);
  localparam int W = FB_W + POST_W;

  p_par_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !par_lock |=> {post_code, fb_div} == $past({post_code_in, fb_div_in}));

  p_par_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_lock && ser_xfer) |=> {post_code, fb_div} == $past({post_code_in, fb_div_in}));

  p_ser_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (par_lock && ser_xfer) |=> {post_code, fb_div} == $past(shift_word));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (par_lock && !ser_xfer) |=> $stable({post_code, fb_div}));

  p_shift_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> shift_word == {$past(shift_word[W-2:0]), $past(ser_din)});

  p_one_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> !shift_evt);
endmodule

bind div_cfg_latch div_cfg_latch_chk #(.FB_W(FB_W), .POST_W(POST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .par_lock(par_lock), .ser_xfer(ser_xfer),
  .ser_din(ser_din), .shift_evt(shift_evt), .shift_word(shift_word),
  .fb_div_in(fb_div_in), .post_code_in(post_code_in),
  .fb_div(fb_div), .post_code(post_code)
);

// File: tb/tb_div_cfg_latch.sv
module tb_div_cfg_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_lock = 1'b1;
  logic [6:0] fb_div_in = '1;
  logic [1:0] post_code_in = '1;
  logic ser_clk = 1'b0, ser_din = 1'b0, ser_xfer = 1'b0;
  logic [6:0] fb_div;
  logic [1:0] post_code;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  div_cfg_latch dut (.*);

  localparam logic [8:0] VEC [6] = '{9'h000, 9'h155, 9'h0AA, 9'h17F, 9'h080, 9'h123};

  task automatic check(input string req, input logic [8:0] exp);
    checks++;
    if ({post_code, fb_div} !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, {post_code, fb_div}, exp);
    end
  endtask

  task automatic shift_word(input logic [8:0] w, input int high_cycles);
    for (int i = 8; i >= 0; i--) begin
      @(negedge clk); ser_din = w[i]; ser_clk = 1'b1;
      for (int k = 1; k < high_cycles; k++) begin
        @(negedge clk); ser_din = ~w[i];
      end
      @(negedge clk); ser_clk = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic transfer();
    @(negedge clk); ser_xfer = 1'b1;
    @(negedge clk); ser_xfer = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 9'h1FF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 9'h1FF);

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      par_lock = 1'b0; {post_code_in, fb_div_in} = VEC[i];
      @(negedge clk);
      check("R2 parallel load", VEC[i]);
      par_lock = 1'b1; {post_code_in, fb_div_in} = ~VEC[i];
      repeat (2) @(negedge clk);
      check("R3 locked ignores inputs", VEC[i]);
    end

    shift_word(9'h0B4, 1);
    check("R6 shift without transfer", VEC[5]);
    transfer();
    check("R4 R5 serial word order", 9'h0B4);
    shift_word(9'h1C3, 1);
    check("R5 holds after transfer falls", 9'h0B4);
    transfer();
    check("R4 second serial word", 9'h1C3);

    shift_word(9'h12D, 4);
    transfer();
    check("R8 long serial clock high", 9'h12D);

    @(negedge clk);
    par_lock = 1'b0; ser_xfer = 1'b1; {post_code_in, fb_div_in} = 9'h05A;
    @(negedge clk);
    check("R7 parallel priority", 9'h05A);
    par_lock = 1'b1; ser_xfer = 1'b0; {post_code_in, fb_div_in} = 9'h1E1;

    repeat (20) @(negedge clk);
    check("R9 idle hold", 9'h05A);

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", 9'h1FF);
    rst_n = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule